// File: doc/BRIEF.md
# Packed Saturating SIMD Arithmetic Unit

This block is a 64-bit packed-integer arithmetic unit. It takes a destination operand and a source operand, each 64 bits wide, together with a 5-bit operation code. When the input strobe is high, it captures the result in an output register, so the result appears one clock after the operands. The operand word can be handled as eight byte lanes, four word lanes or two doubleword lanes, depending on the operation.

The unit supports these operations:
- lane-wise addition, either wrapping or saturating (signed or unsigned);
- equality and signed greater-than compares, which return lane masks;
- narrowing packs that saturate each lane;
- a pairwise signed multiply-add that produces two 32-bit sums.

Register storage, operand fetch and instruction decoding belong to the surrounding datapath.

Top module: `simd_sat_alu`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `res_o` is zero.
- R2: When `in_valid` is high at a rising clock edge, `res_o` shows the result for that cycle's operands after the edge. When `in_valid` is low, `res_o` keeps its previous value, whatever the other inputs do.
- R3: Codes 0, 1 and 2 add byte, word and doubleword lanes respectively, modulo the lane width. No carry passes between lanes.
- R4: Codes 3 (byte) and 4 (word) add lanes as signed values. A sum above the signed maximum (0x7F or 0x7FFF) or below the signed minimum (0x80 or 0x8000) is clamped to that limit.
- R5: Codes 5 (byte) and 6 (word) add lanes as unsigned values. A sum that exceeds 0xFF or 0xFFFF gives 0xFF or 0xFFFF.
- R6: Code 7 forms a 128-bit value with `src_i` as the upper half and `dst_i` as the lower half. It reads that value as four signed doublewords, and doubleword i goes to result word i, saturated to the range 0x8000..0x7FFF.
- R7: Code 8 reads the same 128-bit value as eight signed words. Word i goes to result byte i, saturated to the range 0x80..0x7F.
- R8: Code 9 reads the same 128-bit value as eight signed words. Word i goes to result byte i as follows: a negative word gives 0x00, a word above 0xFF gives 0xFF, and any other word passes through unchanged.
- R9: Codes 10, 11 and 12 compare byte, word and doubleword lanes for equality. Each result lane is all ones when the two lanes are equal and all zeros otherwise.
- R10: Codes 13, 14 and 15 compare byte, word and doubleword lanes as signed values. Each result lane is all ones when the `dst_i` lane is greater than the `src_i` lane and all zeros otherwise.
- R11: Code 16 forms the four signed products of matching word lanes. Result bits 31:0 hold the sum of products 0 and 1, and bits 63:32 hold the sum of products 2 and 3. Both sums wrap at 32 bits.
- R12: Codes 17 to 31 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the result register |
| op_sel | input | 5 | Operation code |
| dst_i | input | 64 | Destination operand (first operand; lower half for packs) |
| src_i | input | 64 | Source operand (second operand; upper half for packs) |
| res_o | output | 64 | Registered packed result |

## Verification
The tests use operands picked to sit on every lane boundary:
- All-ones added to ones shows whether a carry leaks into the next lane.
- Pairs at 0x7F/0x80 and 0x7FFF/0x8000 separate signed clamping from wrapping and from unsigned clamping.
- Pack inputs mix words just above and below each limit, including negative words, so that half order and clamp direction are both exposed.
- Compare operands that differ only in the sign bit separate signed from unsigned ordering.
- Multiply-add with 0x8000 in every lane hits the single 32-bit overflow case.

A long run of random operands, with random codes and the strobe sometimes low, is compared against a lane-by-lane integer model on every clock.

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op_sel,
  input  logic [63:0]    dst_i,
  input  logic [63:0]    src_i,
  output logic [63:0]    res_o
);

  localparam logic [OPW-1:0] ADD_B   = 5'd0,  ADD_W   = 5'd1,  ADD_D   = 5'd2;
  localparam logic [OPW-1:0] ADDS_B  = 5'd3,  ADDS_W  = 5'd4;
  localparam logic [OPW-1:0] ADDU_B  = 5'd5,  ADDU_W  = 5'd6;
  localparam logic [OPW-1:0] PK_SDW  = 5'd7,  PK_SWB  = 5'd8,  PK_UWB  = 5'd9;
  localparam logic [OPW-1:0] EQ_B    = 5'd10, EQ_W    = 5'd11, EQ_D    = 5'd12;
  localparam logic [OPW-1:0] GT_B    = 5'd13, GT_W    = 5'd14, GT_D    = 5'd15;
  localparam logic [OPW-1:0] MADD    = 5'd16;

  logic [127:0]       cat;
  logic signed [31:0] prod [4];
  logic [63:0]        nxt;

  assign cat = {src_i, dst_i};

  for (genvar g = 0; g < 4; g++) begin : g_prod
    assign prod[g] = $signed(dst_i[16*g +: 16]) * $signed(src_i[16*g +: 16]);
  end

  always_comb begin
    logic [8:0]         s9, u9;
    logic [16:0]        s17, u17;
    logic signed [31:0] dw;
    logic signed [15:0] wd;
    nxt = '0;
    s9 = '0; u9 = '0; s17 = '0; u17 = '0; dw = '0; wd = '0;
    case (op_sel)
      ADD_B, ADDS_B, ADDU_B:
        for (int i = 0; i < 8; i++) begin
          s9 = {dst_i[8*i+7], dst_i[8*i +: 8]} + {src_i[8*i+7], src_i[8*i +: 8]};
          u9 = {1'b0, dst_i[8*i +: 8]} + {1'b0, src_i[8*i +: 8]};
          if (op_sel == ADDS_B && s9[8] != s9[7])
            nxt[8*i +: 8] = s9[8] ? 8'h80 : 8'h7F;
          else if (op_sel == ADDU_B && u9[8])
            nxt[8*i +: 8] = 8'hFF;
          else
            nxt[8*i +: 8] = u9[7:0];
        end
      ADD_W, ADDS_W, ADDU_W:
        for (int i = 0; i < 4; i++) begin
          s17 = {dst_i[16*i+15], dst_i[16*i +: 16]} + {src_i[16*i+15], src_i[16*i +: 16]};
          u17 = {1'b0, dst_i[16*i +: 16]} + {1'b0, src_i[16*i +: 16]};
          if (op_sel == ADDS_W && s17[16] != s17[15])
            nxt[16*i +: 16] = s17[16] ? 16'h8000 : 16'h7FFF;
          else if (op_sel == ADDU_W && u17[16])
            nxt[16*i +: 16] = 16'hFFFF;
          else
            nxt[16*i +: 16] = u17[15:0];
        end
      ADD_D:
        for (int i = 0; i < 2; i++)
          nxt[32*i +: 32] = dst_i[32*i +: 32] + src_i[32*i +: 32];
      PK_SDW:
        for (int i = 0; i < 4; i++) begin
          dw = $signed(cat[32*i +: 32]);
          if (dw > 32'sd32767)       nxt[16*i +: 16] = 16'h7FFF;
          else if (dw < -32'sd32768) nxt[16*i +: 16] = 16'h8000;
          else                       nxt[16*i +: 16] = dw[15:0];
        end
      PK_SWB, PK_UWB:
        for (int i = 0; i < 8; i++) begin
          wd = $signed(cat[16*i +: 16]);
          if (op_sel == PK_UWB) begin
            if (wd < 16'sd0)        nxt[8*i +: 8] = 8'h00;
            else if (wd > 16'sd255) nxt[8*i +: 8] = 8'hFF;
            else                    nxt[8*i +: 8] = wd[7:0];
          end else begin
            if (wd > 16'sd127)       nxt[8*i +: 8] = 8'h7F;
            else if (wd < -16'sd128) nxt[8*i +: 8] = 8'h80;
            else                     nxt[8*i +: 8] = wd[7:0];
          end
        end
      EQ_B, GT_B:
        for (int i = 0; i < 8; i++)
          nxt[8*i +: 8] = {8{(op_sel == EQ_B) ? (dst_i[8*i +: 8] == src_i[8*i +: 8])
                                              : ($signed(dst_i[8*i +: 8]) > $signed(src_i[8*i +: 8]))}};
      EQ_W, GT_W:
        for (int i = 0; i < 4; i++)
          nxt[16*i +: 16] = {16{(op_sel == EQ_W) ? (dst_i[16*i +: 16] == src_i[16*i +: 16])
                                                 : ($signed(dst_i[16*i +: 16]) > $signed(src_i[16*i +: 16]))}};
      EQ_D, GT_D:
        for (int i = 0; i < 2; i++)
          nxt[32*i +: 32] = {32{(op_sel == EQ_D) ? (dst_i[32*i +: 32] == src_i[32*i +: 32])
                                                 : ($signed(dst_i[32*i +: 32]) > $signed(src_i[32*i +: 32]))}};
      MADD: begin
        nxt[31:0]  = prod[0] + prod[1];
        nxt[63:32] = prod[2] + prod[3];
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        res_o <= '0;
    else if (in_valid) res_o <= nxt;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    disable iff (!rst_n) !$past(rst_n) |-> res_o == 64'd0);

  assert_hold_idle_R2: assert property (@(posedge clk)
    disable iff (!rst_n) (!in_valid && $past(rst_n)) |=> $stable(res_o));

  assert_usat_floor_R5: assert property (@(posedge clk)
    disable iff (!rst_n) (in_valid && op_sel == ADDU_W) |=> res_o[15:0] >= $past(dst_i[15:0]));

  assert_eq_mask_R9: assert property (@(posedge clk)
    disable iff (!rst_n) (in_valid && op_sel == EQ_D) |=>
      ((res_o[31:0] == 32'd0 || res_o[31:0] == 32'hFFFF_FFFF) &&
       (res_o[63:32] == 32'd0 || res_o[63:32] == 32'hFFFF_FFFF)));

  assert_madd_zero_R11: assert property (@(posedge clk)
    disable iff (!rst_n) (in_valid && op_sel == MADD && src_i == 64'd0) |=> res_o == 64'd0);

  assert_reserved_zero_R12: assert property (@(posedge clk)
    disable iff (!rst_n) (in_valid && op_sel > MADD) |=> res_o == 64'd0);

endmodule

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [63:0] dst_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] res_o;
  logic [63:0] exp_r = '0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sat_alu u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
                      .dst_i(dst_i), .src_i(src_i), .res_o(res_o));

  function automatic longint uget(logic [63:0] x, int w, int i);
    return longint'((x >> (w*i)) & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic longint sget(logic [63:0] x, int w, int i);
    longint v = uget(x, w, i);
    if (v >= (longint'(1) <<< (w-1))) v = v - (longint'(1) <<< w);
    return v;
  endfunction

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [63:0] put(logic [63:0] r, longint v, int w, int i);
    return r | ((64'(v) & ((64'd1 << w) - 64'd1)) << (w*i));
  endfunction

  function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int w;
    longint s, lim;
    if (op <= 6) begin
      w = (op == 0 || op == 3 || op == 5) ? 8 : (op == 2) ? 32 : 16;
      lim = longint'(1) <<< (w-1);
      for (int i = 0; i < 64/w; i++) begin
        if (op == 3 || op == 4) s = clampl(sget(a,w,i) + sget(b,w,i), -lim, lim-1);
        else if (op >= 5)       s = clampl(uget(a,w,i) + uget(b,w,i), 0, 2*lim-1);
        else                    s = uget(a,w,i) + uget(b,w,i);
        r = put(r, s, w, i);
      end
    end else if (op == 7) begin
      for (int i = 0; i < 4; i++)
        r = put(r, clampl(sget((i < 2) ? a : b, 32, i % 2), -32768, 32767), 16, i);
    end else if (op == 8 || op == 9) begin
      for (int i = 0; i < 8; i++) begin
        s = sget((i < 4) ? a : b, 16, i % 4);
        r = put(r, (op == 8) ? clampl(s, -128, 127) : clampl(s, 0, 255), 8, i);
      end
    end else if (op >= 10 && op <= 15) begin
      w = 8 << ((op - 10) % 3);
      for (int i = 0; i < 64/w; i++) begin
        if (op <= 12) s = (uget(a,w,i) == uget(b,w,i)) ? -1 : 0;
        else          s = (sget(a,w,i) >  sget(b,w,i)) ? -1 : 0;
        r = put(r, s, w, i);
      end
    end else if (op == 16) begin
      r = put(r, sget(a,16,0)*sget(b,16,0) + sget(a,16,1)*sget(b,16,1), 32, 0);
      r = put(r, sget(a,16,2)*sget(b,16,2) + sget(a,16,3)*sget(b,16,3), 32, 1);
    end
    return r;
  endfunction

  function automatic string tag_of(int op, bit v);
    if (!v) return "R2";
    case (op)
      0, 1, 2:     return "R3";
      3, 4:        return "R4";
      5, 6:        return "R5";
      7:           return "R6";
      8:           return "R7";
      9:           return "R8";
      10, 11, 12:  return "R9";
      13, 14, 15:  return "R10";
      16:          return "R11";
      default:     return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] want);
    checks++;
    if (res_o !== want) begin
      errors++;
      $display("FAIL %s: op=%0d got %h expected %h", tag, op_sel, res_o, want);
    end
  endtask

  task automatic step(int op, logic [63:0] a, logic [63:0] b, bit v);
    @(negedge clk);
    op_sel = 5'(op); dst_i = a; src_i = b; in_valid = v;
    @(posedge clk);
    if (v) exp_r = model(op, a, b);
    @(negedge clk);
    check(tag_of(op, v), exp_r);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    in_valid = 1'b1; op_sel = 5'd16; dst_i = '1; src_i = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 64'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", 64'd0);

    // R3 lane isolation: carries must not cross lanes
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1);
    step(1, 64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001, 1);
    step(2, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 1);
    // R4 signed clamps
    step(3, 64'h7F80_7F80_0102_FF00, 64'h01FF_7F80_7F80_FF01, 1);
    step(4, 64'h7FFF_8000_7FFF_1234, 64'h0001_FFFF_8000_1111, 1);
    // R5 unsigned clamps
    step(5, 64'hFF80_7F01_00FE_FF7F, 64'h0180_8100_0001_FF80, 1);
    step(6, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_FFFE_8000, 1);
    // R6 dword-to-word pack, dst low half / src high half
    step(7, 64'hFFFF_0000_0001_0000, 64'h0000_1234_FFFF_8000, 1);
    step(7, 64'h0000_7FFF_FFFF_7FFF, 64'h8000_0000_7FFF_FFFF, 1);
    // R7 signed word-to-byte pack
    step(8, 64'h0080_FF7F_007F_FF80, 64'h8000_7FFF_0001_FFFF, 1);
    // R8 unsigned word-to-byte pack, negatives to zero
    step(9, 64'h8000_0100_00FF_0000, 64'hFFFF_7FFF_0080_0001, 1);
    // R9 equality masks
    step(10, 64'h1122_3344_5566_7788, 64'h1100_3344_0066_7788, 1);
    step(12, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0000, 1);
    // R10 signed greater-than: sign bit decides
    step(13, 64'h7F80_0001_FF00_8000, 64'h807F_00FF_0000_7F00, 1);
    step(14, 64'h0001_8000_7FFF_FFFF, 64'hFFFF_7FFF_8000_FFFF, 1);
    step(15, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 1);
    // R11 multiply-add including the wrap case
    step(16, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1);
    step(16, 64'h0003_FFFE_7FFF_0002, 64'h0004_0005_7FFF_FFFD, 1);
    // R12 reserved codes
    step(17, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, 1);
    step(31, '1, '1, 1);
    // R2 hold while strobe low
    step(1, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040, 1);
    step(16, '1, 64'h1234, 0);
    step(7, 64'h5, 64'h6, 0);

    for (int n = 0; n < 3000; n++)
      step(int'($urandom_range(0, 31)), {$urandom, $urandom}, {$urandom, $urandom},
           ($urandom_range(0, 4) != 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule